// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Takeover

This block controls eight bidirectional pins from a small register interface. Software sets the direction of each pin and the value each output pin drives. It can also read the live level of every pin. Each pin presents an output-enable and an output-data signal to a pad model, and it returns the pad level on its input.

A peripheral that needs the lower seven pins raises a single enable. While that enable is high, pins 6 to 0 are held as inputs. Their stored direction bits stay untouched and take effect again once the enable falls. Pin 7 always follows its own direction bit.

Pin levels reach the read path through a two-flop synchronizer on the bus clock. Any change on a pin, including one caused by a direction change, therefore shows in the read data two clock edges later.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the direction register, the output-data register and both synchronizer stages. After reset every pin is an input, `pad_oe` is 0x00, and all three registers read 0x00.
- R2: The direction register is at offset 0x12 and reads back the last value written. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. With the takeover inactive, `pad_oe` equals the direction register.
- R3: The output-data register is at offset 0x10 and reads back the last value written. For each pin, `pad_do[n]` carries bit n of this register when the pin's effective direction is output, and is 0 otherwise.
- R4: While `periph_en` is 1, `pad_oe[6:0]` is 0 whatever the direction bits hold, and `pad_do[6:0]` is 0. `pad_oe[7]` still equals direction bit 7.
- R5: The stored direction value is kept through a takeover and reads back unchanged at 0x12. When `periph_en` returns to 0, `pad_oe[6:0]` again follows direction bits 6 to 0.
- R6: The pin input register is at offset 0x11 and returns the pins through two flops. A pin level present before clock edge k is not yet visible after edge k, and it is visible after edge k+1.
- R7: The pin input register returns the pin level for output pins as well. A pin driven against its output data reads the level actually on the pin, so a short can be seen.
- R8: A write to offset 0x11 changes no state. The direction and output-data registers and the pad outputs stay as they were.
- R9: A read of any offset other than 0x10, 0x11 or 0x12 returns 0x00. A write to such an offset changes no state.
- R10: A write takes effect only in a cycle where `bus_sel` and `bus_wr` are both 1. A read returns 0x00 when `bus_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset within the port's window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| periph_en | input | 1 | Peripheral takes pins 6 to 0 when high |
| pin_in | input | 8 | Level present on each pad |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output data |

## Verification
A direction write and a change of the peripheral enable can land on the same clock edge. The bench writes 0x81 to the direction register in the very cycle it raises the enable. It then expects only pin 7 enabled while the register reads back 0x81. When the enable falls, it expects pins 0 and 7 enabled. A direction change can also coincide with the synchronizer carrying an older pin level. A looped-back pad is read one and two edges after the write, and the bench expects the old level first and the driven level second.

// File: rtl/gpio_port_pkg.sv
// Package: gpio_port_pkg
// Holds the register offsets shared by the port controller, its checker
// and anything that decodes the port's address window.
// Assumes an 8-bit offset within the window.
package gpio_port_pkg;
    localparam int unsigned OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_OUTDATA = 8'h10;
    localparam logic [OFS_W-1:0] OFS_PINS    = 8'h11;
    localparam logic [OFS_W-1:0] OFS_DIR     = 8'h12;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_OUTDATA = 2'd1,
        SEL_PINS    = 2'd2,
        SEL_DIR     = 2'd3
    } reg_sel_e;

    // Map an offset onto the register it names (SEL_NONE when unmapped).
    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_OUTDATA: sel = SEL_OUTDATA;
            OFS_PINS:    sel = SEL_PINS;
            OFS_DIR:     sel = SEL_DIR;
            default:     sel = SEL_NONE;
        endcase
        return sel;
    endfunction
endpackage

// File: rtl/gpio_port_sync.sv
// Module: gpio_port_sync
// Multi-stage flop synchronizer for a vector of pad inputs, clocked by the
// bus clock. Each bit is treated on its own; no coherence across bits is
// promised. Assumes STAGES >= 1. Reset clears every stage.
module gpio_port_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;

        // Select the feed of this stage: the pads for the first, else the previous stage.
        if (s == 0) begin : g_first
            always_comb stage_d = async_in;
        end else begin : g_next
            always_comb stage_d = stage_q[s-1];
        end

        // Capture this stage on every bus clock edge.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs
// Storage for the direction and output-data registers. Write strobes come
// already decoded from the top; a strobe loads the full byte.
// Assumes at most one strobe is used per write access.
module gpio_port_regs #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_outdata,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] outdata_q
);
    // Direction register: 1 = output, cleared to all inputs on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output-data register: value driven on pins whose direction is output.
    always_ff @(posedge clk) begin
        if (!rst_n)          outdata_q <= '0;
        else if (wr_outdata) outdata_q <= wdata;
    end
endmodule

// File: rtl/gpio_port_dirmux.sv
// Module: gpio_port_dirmux
// Per-pin effective direction. Pins below OVR_W are forced to input while the
// peripheral enable is high; pins at or above OVR_W always follow their
// direction bit. Output data is gated to zero on pins not enabled.
// Assumes OVR_W <= WIDTH. Purely combinational.
module gpio_port_dirmux #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned OVR_W = 7
) (
    input  logic             periph_en,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] outdata_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i < OVR_W) begin : g_shared
            // Shared pin: the peripheral's enable takes priority over the direction bit.
            always_comb pad_oe[i] = dir_q[i] & ~periph_en;
        end else begin : g_own
            // Port-only pin: the direction bit alone decides.
            always_comb pad_oe[i] = dir_q[i];
        end

        // Drive data only where the pin is an effective output.
        always_comb pad_do[i] = pad_oe[i] & outdata_q[i];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: gpio_port_ctrl
// Eight-pin I/O port: register decode, read multiplexer, direction override
// for a peripheral sharing the low pins, and a synchronized pin readback.
// Assumes a single-cycle access: writes land on the edge where bus_sel and
// bus_wr are high; read data is combinational from the offset.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_W       = 8,
    parameter int unsigned OVR_W       = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [PIN_W-1:0] bus_wdata,
    output logic [PIN_W-1:0] bus_rdata,
    input  logic             periph_en,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] pad_do
);
    localparam int unsigned OVR_EFF = (OVR_W > PIN_W) ? PIN_W : OVR_W;

    reg_sel_e         acc_sel;
    logic             wr_dir;
    logic             wr_outdata;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] outdata_q;
    logic [PIN_W-1:0] pins_sync;

    // Decode the offset and form write strobes; pin register has no strobe.
    always_comb begin
        acc_sel    = decode_ofs(bus_addr);
        wr_dir     = bus_sel & bus_wr & (acc_sel == SEL_DIR);
        wr_outdata = bus_sel & bus_wr & (acc_sel == SEL_OUTDATA);
    end

    gpio_port_regs #(
        .WIDTH (PIN_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_dir     (wr_dir),
        .wr_outdata (wr_outdata),
        .wdata      (bus_wdata),
        .dir_q      (dir_q),
        .outdata_q  (outdata_q)
    );

    gpio_port_dirmux #(
        .WIDTH (PIN_W),
        .OVR_W (OVR_EFF)
    ) u_dirmux (
        .periph_en (periph_en),
        .dir_q     (dir_q),
        .outdata_q (outdata_q),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do)
    );

    gpio_port_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    // Return the addressed register on a read; zero when idle or unmapped.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (acc_sel)
                SEL_OUTDATA: bus_rdata = outdata_q;
                SEL_PINS:    bus_rdata = pins_sync;
                SEL_DIR:     bus_rdata = dir_q;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
// Module: gpio_port_ctrl_chk
// Port-level properties of gpio_port_ctrl, attached with bind below.
// Assumes the default of two synchronizer stages for the readback property.
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_W = 8,
    parameter int unsigned OVR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [OFS_W-1:0] bus_addr,
    input logic [PIN_W-1:0] bus_wdata,
    input logic [PIN_W-1:0] bus_rdata,
    input logic             periph_en,
    input logic [PIN_W-1:0] pin_in,
    input logic [PIN_W-1:0] pad_oe,
    input logic [PIN_W-1:0] pad_do
);
    localparam logic [PIN_W-1:0] OVR_MASK = PIN_W'((1 << OVR_W) - 1);

    logic [1:0] since_rst;

    // Count edges since reset release so the readback check waits for fill.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pad_oe == '0));

    assert_override_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |-> ((pad_oe & OVR_MASK) == '0) && ((pad_do & OVR_MASK) == '0));

    assert_top_pin_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_DIR)
            |=> pad_oe[PIN_W-1] == $past(bus_wdata[PIN_W-1]));

    assert_do_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_do & ~pad_oe) == '0);

    assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && bus_sel && !bus_wr && bus_addr == OFS_PINS)
            |-> bus_rdata == $past(pin_in, 2));

    assert_dead_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != OFS_DIR && bus_addr != OFS_OUTDATA)
            |=> (pad_oe == $past(pad_oe) && pad_do == $past(pad_do))
                || (periph_en != $past(periph_en)));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr != OFS_DIR && bus_addr != OFS_OUTDATA
            && bus_addr != OFS_PINS) |-> bus_rdata == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .PIN_W (PIN_W),
    .OVR_W (OVR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .periph_en (periph_en),
    .pin_in    (pin_in),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do)
);

// File: tb/gpio_port_ctrl_tb.sv
// Bench: gpio_port_ctrl_tb
// Directed scenarios with a looped-back pad model; each task checks itself.
module gpio_port_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_wr;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       periph_en;
    logic [7:0] pin_in, pad_oe, pad_do;
    logic [7:0] ext_val, short_mask, short_val;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad model: driven pins loop back, others take the external level; a short wins.
    assign pin_in = (short_mask & short_val)
                  | (~short_mask & ((pad_oe & pad_do) | (~pad_oe & ext_val)));

    gpio_port_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .periph_en (periph_en),
        .pin_in    (pin_in),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h12, v); check("R1 dir after reset", v, 8'h00);
        rd(8'h10, v); check("R1 outdata after reset", v, 8'h00);
        rd(8'h11, v); check("R1 pins after reset", v, 8'h00);
        check("R1 pad_oe after reset", pad_oe, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(8'h12, 8'hA5);
        rd(8'h12, v); check("R2 dir readback", v, 8'hA5);
        check("R2 pad_oe follows dir", pad_oe, 8'hA5);
        wr(8'h10, 8'h3C);
        rd(8'h10, v); check("R3 outdata readback", v, 8'h3C);
        check("R3 pad_do gated", pad_do, 8'h24);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(8'h12, 8'h00);
        ext_val = 8'h00;
        repeat (3) @(negedge clk);
        ext_val = 8'h5A;
        @(negedge clk);
        rd(8'h11, v); check("R6 not visible after one edge", v, 8'h00);
        @(negedge clk);
        rd(8'h11, v); check("R6 visible after two edges", v, 8'h5A);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        ext_val = 8'h00;
        wr(8'h10, 8'h97);
        wr(8'h12, 8'hFF);
        rd(8'h11, v); check("R6 dir change not yet seen", v, 8'h00);
        repeat (2) @(negedge clk);
        rd(8'h11, v); check("R7 output pins read back", v, 8'h97);
        short_mask = 8'h01; short_val = 8'h00;
        repeat (2) @(negedge clk);
        rd(8'h11, v); check("R7 shorted pin shows pad level", v, 8'h96);
        short_mask = 8'h00;
    endtask

    task automatic t_override();
        logic [7:0] v;
        wr(8'h12, 8'hFF);
        periph_en = 1'b1;
        #1 check("R4 low pins forced input", pad_oe, 8'h80);
        check("R4 low pins no data", pad_do & 8'h7F, 8'h00);
        rd(8'h12, v); check("R5 dir kept during takeover", v, 8'hFF);
        wr(8'h12, 8'h7F);
        check("R4 pin 7 follows its bit", pad_oe, 8'h00);
        wr(8'h12, 8'hFF);
        periph_en = 1'b0;
        #1 check("R5 control returns", pad_oe, 8'hFF);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h12; bus_wdata = 8'h81;
        periph_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R4 write with takeover", pad_oe, 8'h80);
        rd(8'h12, v); check("R5 dir stored in takeover cycle", v, 8'h81);
        periph_en = 1'b0;
        #1 check("R5 stored dir applied", pad_oe, 8'h81);
    endtask

    task automatic t_dead_writes();
        logic [7:0] v;
        wr(8'h12, 8'h0F);
        wr(8'h10, 8'h33);
        wr(8'h11, 8'hF0);
        rd(8'h12, v); check("R8 dir untouched by pin write", v, 8'h0F);
        rd(8'h10, v); check("R8 outdata untouched by pin write", v, 8'h33);
        check("R8 pad_oe unchanged", pad_oe, 8'h0F);
        rd(8'h13, v); check("R9 unmapped read zero", v, 8'h00);
        rd(8'h00, v); check("R9 offset zero reads zero", v, 8'h00);
        wr(8'h13, 8'hFF);
        wr(8'h02, 8'hFF);
        rd(8'h12, v); check("R9 dir untouched by unmapped write", v, 8'h0F);
        rd(8'h10, v); check("R9 outdata untouched by unmapped write", v, 8'h33);
    endtask

    task automatic t_nosel();
        logic [7:0] v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 8'h12; bus_wdata = 8'hC3;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h12, v); check("R10 write without select ignored", v, 8'h0F);
        bus_addr = 8'h12;
        #1 check("R10 idle read is zero", bus_rdata, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        periph_en = 1'b0; ext_val = 8'h00; short_mask = 8'h00; short_val = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sync();
        t_loop();
        t_override();
        t_same_cycle();
        t_dead_writes();
        t_nosel();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1-R10 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule